// File: doc/BRIEF.md
# D-PHY Receive Startup Sequencer

This block brings a receive-only D-PHY out of reset and into normal operation after a single start command. When started, it samples a lane count and a link data rate in Mbps. From the rate it selects a 6-bit frequency band code out of a fixed range table. It sets the per-lane control outputs and then drives the PHY's test-clear line high and low, each level held for a set wait.

After the clear pulse, the block programs the PHY through its four-wire test port: a test clock, a test clear, an address/data strobe and an 8-bit data bus. It performs seven register writes in a fixed order. Each write presents the register code and latches it on a falling test-clock edge while the strobe is high. It then presents the data and commits it on the next rising edge while the strobe is low. When the last write has been committed, the block raises a one-cycle done pulse. The lane settings and the test clock level stay as they are until the next start.

All control inputs and status outputs are plain levels or pulses; no data stream crosses the block edge, so there is no valid/ready handshake at the ports. Inside the block, the sequencer hands each write to the test-port writer over a valid/ready pair. The writer holds ready low while a write is in flight, and the sequencer keeps its request and payload stable until the request is accepted.

Top module: `dphy_rx_bringup`

## Requirements
- R1: After reset, every output is 0: lane enable, turn-disable, test clock, test clear, strobe, test data, busy, done, out-of-range and band.
- R2: The band output is the code of the first entry, in ascending bound order, whose bound is greater than or equal to the sampled rate. The bound:code pairs (code in hex) are 89:00, 99:10, 109:20, 129:01, 139:11, 149:21, 169:02, 179:12, 199:22, 219:03, 239:13, 249:23, 269:04, 299:14, 329:05, 359:15, 399:25, 449:06, 499:16, 549:07, 599:17, 649:08, 699:18, 749:09, 799:19, 849:29, 899:39, 949:0a, 999:1a, 1049:2a, 1099:3a, 1149:0b, 1199:1b, 1249:2b, 1299:3b, 1349:0c, 1399:1c, 1449:2c, 1500:3c.
- R3: A sampled rate above 1500 gives band 0 and raises the out-of-range output; for a rate of 1500 or less that output is low.
- R4: Once started, the 4-bit lane enable has the low N bits set, where N is the lane count clamped to 1..4 (0 acts as 1, 5..7 act as 4). Turn-disable becomes 4'hF. The force-receive, force-stop and turn-request outputs stay 0.
- R5: The test clock is high before the test clear rises. Test clear stays high for exactly CLR_HOLD_CYC cycles. The first strobe rise comes SETTLE_CYC + 1 + 2*STEP_CYC cycles after test clear falls.
- R6: In each write, the code is latched by a falling test-clock edge with the strobe high, and the data is committed by a rising test-clock edge with the strobe low. Every protocol step lasts STEP_CYC cycles, so the strobe is high for 2*STEP_CYC cycles, and the data bus does not change while the strobe is high.
- R7: Exactly seven writes occur, as code:data pairs in this order: 34:00, 44:(band<<1), 54:00, 84:00, 94:00, 75:04, 00:00.
- R8: Busy is high from the cycle after a start is accepted until the last write completes. Done is then high for exactly one cycle, in which busy is already low.
- R9: A start asserted while busy is ignored. The sampled lane count and rate are kept, the write sequence is unchanged, and no new run follows.
- R10: After done, the lane enable, turn-disable, band and test clock (high) keep their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, accepted only while idle |
| lanes_i | input | 3 | Number of active data lanes (1..4, clamped) |
| rate_i | input | RATE_W | Link data rate in Mbps |
| lane_en_o | output | 4 | Per-lane enable |
| force_rx_o | output | 4 | Per-lane force-receive control (held 0) |
| force_stop_o | output | 4 | Per-lane force-stop control (held 0) |
| turn_req_o | output | 4 | Per-lane turnaround request (held 0) |
| turn_dis_o | output | 4 | Per-lane turnaround disable |
| tst_clk_o | output | 1 | Test-port clock |
| tst_clr_o | output | 1 | Test-port clear |
| tst_en_o | output | 1 | Test-port code strobe |
| tst_din_o | output | 8 | Test-port data bus |
| band_o | output | 6 | Selected frequency band code |
| out_of_range_o | output | 1 | Rate above the last table bound |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions check the per-cycle properties on every cycle. These are the edge discipline of the test port (falling edges only with the strobe high, rising edges only with it low, data stable while the strobe is high), the clock being high when the clear rises, the bound on the clear pulse length, the lane enable taking a legal mask while configured, the single-cycle done pulse, and the sampled configuration holding steady when a start arrives while busy. Only the bench's scenarios can show the rest: the band chosen for each rate, including the bound edges and rates past the table, the exact seven code/data pairs in order as seen by a slave model, the exact clear and settle durations, the clamped lane masks, and the fact that an ignored start leaves no trace after completion.

// File: rtl/dphy_bringup_pkg.sv
package dphy_bringup_pkg;

  // Rate-band table, ascending upper bounds in Mbps.
  localparam int NUM_BANDS = 39;

  localparam int unsigned BAND_TOP [NUM_BANDS] = '{
      89,   99,  109,  129,  139,  149,  169,  179,  199,  219,
     239,  249,  269,  299,  329,  359,  399,  449,  499,  549,
     599,  649,  699,  749,  799,  849,  899,  949,  999, 1049,
    1099, 1149, 1199, 1249, 1299, 1349, 1399, 1449, 1500
  };

  localparam logic [5:0] BAND_SEL [NUM_BANDS] = '{
    6'h00, 6'h10, 6'h20, 6'h01, 6'h11, 6'h21, 6'h02, 6'h12, 6'h22, 6'h03,
    6'h13, 6'h23, 6'h04, 6'h14, 6'h05, 6'h15, 6'h25, 6'h06, 6'h16, 6'h07,
    6'h17, 6'h08, 6'h18, 6'h09, 6'h19, 6'h29, 6'h39, 6'h0a, 6'h1a, 6'h2a,
    6'h3a, 6'h0b, 6'h1b, 6'h2b, 6'h3b, 6'h0c, 6'h1c, 6'h2c, 6'h3c
  };

  localparam int NUM_WRITES = 7;
  localparam int TDW        = 8;
  localparam int NLANE      = 4;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SETUP,
    S_CLR_HI,
    S_CLR_LO,
    S_WRITE
  } seq_state_e;

  // Test-port write phases, in protocol order.
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CLK_UP,
    PH_CODE,
    PH_EN_UP,
    PH_CLK_DN,
    PH_EN_DN,
    PH_DATA,
    PH_CLK_UP2
  } wr_phase_e;

  function automatic logic [TDW-1:0] seq_code(input logic [2:0] idx);
    case (idx)
      3'd0:    seq_code = 8'h34;
      3'd1:    seq_code = 8'h44;
      3'd2:    seq_code = 8'h54;
      3'd3:    seq_code = 8'h84;
      3'd4:    seq_code = 8'h94;
      3'd5:    seq_code = 8'h75;
      default: seq_code = 8'h00;
    endcase
  endfunction

  function automatic logic [TDW-1:0] seq_data(input logic [2:0] idx,
                                              input logic [5:0] band);
    case (idx)
      3'd1:    seq_data = {1'b0, band, 1'b0};
      3'd5:    seq_data = 8'h04;
      default: seq_data = 8'h00;
    endcase
  endfunction

  function automatic logic [NLANE-1:0] lane_mask(input logic [2:0] n);
    case (n)
      3'd0, 3'd1: lane_mask = 4'b0001;
      3'd2:       lane_mask = 4'b0011;
      3'd3:       lane_mask = 4'b0111;
      default:    lane_mask = 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/dphy_band_lookup.sv
module dphy_band_lookup
  import dphy_bringup_pkg::*;
#(
  parameter int RATE_W = 11
) (
  input  logic [RATE_W-1:0] rate_i,
  output logic [5:0]        band_o,
  output logic              oor_o
);

  logic [NUM_BANDS-1:0] hit;

  // One comparator per table entry.
  for (genvar g = 0; g < NUM_BANDS; g++) begin : g_cmp
    assign hit[g] = (32'(rate_i) <= BAND_TOP[g]);
  end

  // Lowest matching entry wins.
  always_comb begin
    band_o = '0;
    oor_o  = 1'b1;
    for (int i = NUM_BANDS - 1; i >= 0; i--) begin
      if (hit[i]) begin
        band_o = BAND_SEL[i];
        oor_o  = 1'b0;
      end
    end
  end

endmodule

// File: rtl/dphy_test_writer.sv
module dphy_test_writer
  import dphy_bringup_pkg::*;
#(
  parameter int STEP_CYC = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           park_hi_i,
  input  logic           valid_i,
  output logic           ready_o,
  input  logic [TDW-1:0] code_i,
  input  logic [TDW-1:0] data_i,
  output logic           tst_clk_o,
  output logic           tst_en_o,
  output logic [TDW-1:0] tst_din_o
);

  localparam int SW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;

  wr_phase_e      phase;
  logic [SW-1:0]  hold;
  logic [TDW-1:0] code_q, data_q, din_q;
  logic           park_q;
  wr_phase_e      phase_nx;

  assign ready_o = (phase == PH_IDLE);

  always_comb begin
    if (phase == PH_CLK_UP2) phase_nx = PH_IDLE;
    else                     phase_nx = wr_phase_e'(phase + 3'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      hold   <= '0;
      code_q <= '0;
      data_q <= '0;
      din_q  <= '0;
      park_q <= 1'b0;
    end else begin
      if (park_hi_i) park_q <= 1'b1;
      if (phase == PH_IDLE) begin
        if (valid_i) begin
          code_q <= code_i;
          data_q <= data_i;
          hold   <= '0;
          phase  <= PH_CLK_UP;
        end
      end else if (hold == SW'(STEP_CYC - 1)) begin
        hold  <= '0;
        phase <= phase_nx;
        if (phase_nx == PH_CODE) din_q <= code_q;
        if (phase_nx == PH_DATA) din_q <= data_q;
      end else begin
        hold <= hold + 1'b1;
      end
    end
  end

  always_comb begin
    unique case (phase)
      PH_IDLE:                                  tst_clk_o = park_q;
      PH_CLK_UP, PH_CODE, PH_EN_UP, PH_CLK_UP2: tst_clk_o = 1'b1;
      default:                                  tst_clk_o = 1'b0;
    endcase
  end

  assign tst_en_o  = (phase == PH_EN_UP) || (phase == PH_CLK_DN);
  assign tst_din_o = din_q;

  // R6
  fall_with_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tst_clk_o) |-> tst_en_o);
  // R6
  rise_without_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tst_clk_o) |-> !tst_en_o);
  // R6
  din_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tst_en_o && $past(tst_en_o)) |-> $stable(tst_din_o));

endmodule

// File: rtl/dphy_bringup_ctrl.sv
module dphy_bringup_ctrl
  import dphy_bringup_pkg::*;
#(
  parameter int RATE_W       = 11,
  parameter int CLR_HOLD_CYC = 5000,
  parameter int SETTLE_CYC   = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [2:0]        lanes_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [5:0]        band_i,
  output logic [RATE_W-1:0] rate_q_o,
  output logic [NLANE-1:0]  lane_en_o,
  output logic [NLANE-1:0]  turn_dis_o,
  output logic              clr_o,
  output logic              park_hi_o,
  output logic              wr_valid_o,
  output logic [TDW-1:0]    wr_code_o,
  output logic [TDW-1:0]    wr_data_o,
  input  logic              wr_ready_i,
  output logic              busy_o,
  output logic              done_o
);

  localparam int WMAX = (CLR_HOLD_CYC > SETTLE_CYC) ? CLR_HOLD_CYC : SETTLE_CYC;
  localparam int CW   = $clog2(WMAX + 1);

  seq_state_e        state;
  logic [CW-1:0]     cnt;
  logic [2:0]        idx;
  logic [2:0]        lanes_q;
  logic [RATE_W-1:0] rate_q;
  logic [NLANE-1:0]  lane_en_q, turn_dis_q;
  logic              done_q;
  logic              last_wr;

  assign last_wr = (idx == 3'(NUM_WRITES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      idx        <= '0;
      lanes_q    <= '0;
      rate_q     <= '0;
      lane_en_q  <= '0;
      turn_dis_q <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (start_i) begin
            lanes_q <= lanes_i;
            rate_q  <= rate_i;
            state   <= S_SETUP;
          end
        end
        S_SETUP: begin
          lane_en_q  <= lane_mask(lanes_q);
          turn_dis_q <= '1;
          cnt        <= '0;
          state      <= S_CLR_HI;
        end
        S_CLR_HI: begin
          if (cnt == CW'(CLR_HOLD_CYC - 1)) begin
            cnt   <= '0;
            state <= S_CLR_LO;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_CLR_LO: begin
          if (cnt == CW'(SETTLE_CYC - 1)) begin
            cnt   <= '0;
            idx   <= '0;
            state <= S_WRITE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_WRITE: begin
          if (last_wr) begin
            if (wr_ready_i) begin
              state  <= S_IDLE;
              done_q <= 1'b1;
            end
          end else if (wr_ready_i) begin
            idx <= idx + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign park_hi_o  = (state == S_IDLE) && start_i;
  assign clr_o      = (state == S_CLR_HI);
  assign wr_valid_o = (state == S_WRITE) && !last_wr;
  assign wr_code_o  = seq_code(idx);
  assign wr_data_o  = seq_data(idx, band_i);
  assign busy_o     = (state != S_IDLE);
  assign done_o     = done_q;
  assign rate_q_o   = rate_q;
  assign lane_en_o  = lane_en_q;
  assign turn_dis_o = turn_dis_q;

  // Length of the current clear pulse, for the bound check.
  logic [CW:0] clr_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     clr_run <= '0;
    else if (clr_o) clr_run <= clr_run + 1'b1;
    else            clr_run <= '0;
  end

  // R5
  clr_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_o |-> (32'(clr_run) < CLR_HOLD_CYC));
  // R9
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(lanes_q) && $stable(rate_q)));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o ##1 !done_o));
  // R4
  lane_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && state != S_SETUP) |->
      (lane_en_o == 4'h1 || lane_en_o == 4'h3 || lane_en_o == 4'h7 || lane_en_o == 4'hF));

endmodule

// File: rtl/dphy_rx_bringup.sv
module dphy_rx_bringup
  import dphy_bringup_pkg::*;
#(
  parameter int RATE_W       = 11,
  parameter int CLR_HOLD_CYC = 5000,
  parameter int SETTLE_CYC   = 5000,
  parameter int STEP_CYC     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [2:0]        lanes_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic [3:0]        lane_en_o,
  output logic [3:0]        force_rx_o,
  output logic [3:0]        force_stop_o,
  output logic [3:0]        turn_req_o,
  output logic [3:0]        turn_dis_o,
  output logic              tst_clk_o,
  output logic              tst_clr_o,
  output logic              tst_en_o,
  output logic [7:0]        tst_din_o,
  output logic [5:0]        band_o,
  output logic              out_of_range_o,
  output logic              busy_o,
  output logic              done_o
);

  logic [RATE_W-1:0] rate_q;
  logic [5:0]        band;
  logic              oor;
  logic              park_hi, wr_valid, wr_ready;
  logic [TDW-1:0]    wr_code, wr_data;

  dphy_band_lookup #(.RATE_W(RATE_W)) u_band (
    .rate_i (rate_q),
    .band_o (band),
    .oor_o  (oor)
  );

  dphy_bringup_ctrl #(
    .RATE_W       (RATE_W),
    .CLR_HOLD_CYC (CLR_HOLD_CYC),
    .SETTLE_CYC   (SETTLE_CYC)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .lanes_i    (lanes_i),
    .rate_i     (rate_i),
    .band_i     (band),
    .rate_q_o   (rate_q),
    .lane_en_o  (lane_en_o),
    .turn_dis_o (turn_dis_o),
    .clr_o      (tst_clr_o),
    .park_hi_o  (park_hi),
    .wr_valid_o (wr_valid),
    .wr_code_o  (wr_code),
    .wr_data_o  (wr_data),
    .wr_ready_i (wr_ready),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  dphy_test_writer #(.STEP_CYC(STEP_CYC)) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .park_hi_i (park_hi),
    .valid_i   (wr_valid),
    .ready_o   (wr_ready),
    .code_i    (wr_code),
    .data_i    (wr_data),
    .tst_clk_o (tst_clk_o),
    .tst_en_o  (tst_en_o),
    .tst_din_o (tst_din_o)
  );

  assign band_o         = band;
  assign out_of_range_o = oor;
  assign force_rx_o     = '0;
  assign force_stop_o   = '0;
  assign turn_req_o     = '0;

  // R5
  clk_before_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tst_clr_o) |-> $past(tst_clk_o));
  // R3
  oor_band_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_of_range_o |-> (band_o == 6'd0));

endmodule

// File: tb/sim_dphy_rx_bringup.sv
module sim_dphy_rx_bringup;

  localparam int CLR = 12;
  localparam int SET = 9;
  localparam int STP = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] lanes = '0;
  logic [10:0] rate = '0;
  logic [3:0] lane_en, f_rx, f_stop, t_req, t_dis;
  logic tclk, tclr, ten, busy, done, oor;
  logic [7:0] tdin;
  logic [5:0] band;

  always #10 clk = ~clk;

  dphy_rx_bringup #(.RATE_W(11), .CLR_HOLD_CYC(CLR), .SETTLE_CYC(SET), .STEP_CYC(STP)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .lanes_i(lanes), .rate_i(rate),
    .lane_en_o(lane_en), .force_rx_o(f_rx), .force_stop_o(f_stop), .turn_req_o(t_req),
    .turn_dis_o(t_dis), .tst_clk_o(tclk), .tst_clr_o(tclr), .tst_en_o(ten),
    .tst_din_o(tdin), .band_o(band), .out_of_range_o(oor), .busy_o(busy), .done_o(done)
  );

  int n_checks = 0;
  int n_errs = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected band per the range table (R2/R3).
  function automatic int exp_band(input int r, output bit out_rng);
    int tops [39] = '{89,99,109,129,139,149,169,179,199,219,239,249,269,299,329,359,
                      399,449,499,549,599,649,699,749,799,849,899,949,999,1049,1099,
                      1149,1199,1249,1299,1349,1399,1449,1500};
    int codes [39] = '{'h00,'h10,'h20,'h01,'h11,'h21,'h02,'h12,'h22,'h03,'h13,'h23,
                       'h04,'h14,'h05,'h15,'h25,'h06,'h16,'h07,'h17,'h08,'h18,'h09,
                       'h19,'h29,'h39,'h0a,'h1a,'h2a,'h3a,'h0b,'h1b,'h2b,'h3b,'h0c,
                       'h1c,'h2c,'h3c};
    out_rng = 1'b1;
    for (int i = 0; i < 39; i++)
      if (r <= tops[i]) begin
        out_rng = 1'b0;
        return codes[i];
      end
    return 0;
  endfunction

  function automatic int exp_mask(input int n);
    int m = (n < 1) ? 1 : ((n > 4) ? 4 : n);
    return (1 << m) - 1;
  endfunction

  // Slave model of the test port.
  logic [7:0] got_code [16];
  logic [7:0] got_data [16];
  int n_pairs, clr_w, clr_meas, gap_cnt, gap_meas, en_w, en_bad, clr_clk_bad;
  bit gap_on, pend;
  logic [7:0] pend_code;
  logic p_tclk, p_ten, p_tclr;

  always @(negedge clk) begin
    if (!rst_n) begin
      p_tclk = 0; p_ten = 0; p_tclr = 0; pend = 0;
      clr_w = 0; en_w = 0; gap_on = 0;
    end else begin
      if (gap_on) begin
        gap_cnt++;
        if (ten && !p_ten) begin gap_meas = gap_cnt; gap_on = 0; end
      end
      if (tclr && !p_tclr && !p_tclk) clr_clk_bad++;
      if (tclr) clr_w++;
      if (!tclr && p_tclr) begin
        clr_meas = clr_w; clr_w = 0; gap_on = 1; gap_cnt = 0;
      end
      if (ten) en_w++;
      if (!ten && p_ten) begin
        if (en_w != 2 * STP) en_bad++;
        en_w = 0;
      end
      if (p_tclk && !tclk && ten) begin pend_code = tdin; pend = 1; end
      if (!p_tclk && tclk && !ten && pend) begin
        if (n_pairs < 16) begin
          got_code[n_pairs] = pend_code;
          got_data[n_pairs] = tdin;
        end
        n_pairs++;
        pend = 0;
      end
      p_tclk = tclk; p_ten = ten; p_tclr = tclr;
    end
  end

  task automatic run(input int ln, input int rt, input bit interfere);
    int cyc;
    int eb;
    bit eo;
    logic [7:0] ec [7] = '{8'h34, 8'h44, 8'h54, 8'h84, 8'h94, 8'h75, 8'h00};
    logic [7:0] ed [7];
    logic [3:0] held_en;
    eb = exp_band(rt, eo);
    ed = '{8'h00, 8'(eb << 1), 8'h00, 8'h00, 8'h00, 8'h04, 8'h00};
    n_pairs = 0; en_bad = 0; clr_meas = -1; gap_meas = -1; clr_clk_bad = 0;
    @(negedge clk);
    start = 1; lanes = 3'(ln); rate = 11'(rt);
    @(negedge clk);
    start = 0;
    chk(busy === 1'b1, "R8 busy after start", busy, 1);
    if (interfere) begin
      repeat (30) @(negedge clk);
      start = 1; lanes = 3'(ln ^ 3); rate = 11'(rt ^ 11'h155);
      @(negedge clk);
      start = 0;
    end
    cyc = 0;
    while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
    chk(cyc < 5000, "R8 done reached", cyc, 0);
    chk(busy === 1'b0, "R8 busy low at done", busy, 0);
    chk(band === 6'(eb), "R2 band", band, eb);
    chk(oor === eo, "R3 out of range", oor, eo);
    chk(lane_en === 4'(exp_mask(ln)), "R4 lane enable", lane_en, exp_mask(ln));
    chk(t_dis === 4'hF && f_rx === 0 && f_stop === 0 && t_req === 0,
        "R4 lane controls", {t_dis, f_rx, f_stop, t_req}, 16'hF000);
    chk(n_pairs == 7, "R7 write count", n_pairs, 7);
    for (int i = 0; i < 7; i++) begin
      chk(got_code[i] === ec[i], "R7 code", got_code[i], ec[i]);
      chk(got_data[i] === ed[i], "R7 data", got_data[i], ed[i]);
    end
    chk(clr_meas == CLR, "R5 clear width", clr_meas, CLR);
    chk(gap_meas == SET + 1 + 2 * STP, "R5 settle gap", gap_meas, SET + 1 + 2 * STP);
    chk(clr_clk_bad == 0, "R5 clock high before clear", clr_clk_bad, 0);
    chk(en_bad == 0, "R6 strobe width", en_bad, 0);
    held_en = lane_en;
    @(negedge clk);
    chk(done === 1'b0, "R8 done one cycle", done, 0);
    repeat (12) @(negedge clk);
    chk(busy === 1'b0 && n_pairs == 7, "R9 no restart", n_pairs, 7);
    chk(lane_en === held_en && tclk === 1'b1 && band === 6'(eb) && t_dis === 4'hF,
        "R10 settings held", {lane_en, 3'b0, tclk}, {held_en, 4'h1});
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(lane_en === 0 && t_dis === 0 && tclk === 0 && tclr === 0 && ten === 0 &&
        tdin === 0 && busy === 0 && done === 0 && oor === 0 && band === 0,
        "R1 reset state", {lane_en, t_dis, tdin}, 0);
    rst_n = 1;
    @(negedge clk);
    // Directed corners.
    run(1, 89, 0);
    run(2, 90, 0);
    run(4, 1500, 0);
    run(3, 1501, 0);
    run(0, 0, 0);
    run(7, 999, 1);
    run(4, 449, 1);
    run(5, 2047, 0);
    // Random mix.
    for (int k = 0; k < 10; k++)
      run(int'($urandom_range(0, 7)), int'($urandom_range(0, 1700)), k[0]);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

endmodule